// File: doc/BRIEF.md
# Auto-acknowledging multi-CPU interrupt controller

This block collects `N_SRC` level-sensitive hardware interrupt lines and delivers them to `N_CPU` processors, one interrupt output per CPU. Every source has a single mask bit, a software-trigger bit that is ORed with its hardware line, and an affinity vector naming the CPUs it may reach. Every CPU also owns two inter-processor interrupt (IPI) bits with their own pending and mask state. Either IPI bit can serve as a "self" or an "other" doorbell.

Each CPU has one event register. A read returns the most urgent eligible request for that CPU, and the same read acknowledges it. For a hardware or software-triggered source, the source's mask bit is set. For an IPI, the pending bit is cleared and the IPI mask bit is set. Software re-enables a source by clearing its mask. Separate set and clear registers make every mask or trigger update a single write, so it cannot race the hardware's own masking.

The register bus is a single always-ready port and is never back-pressured. `bus_valid` qualifies an access, and read data is returned combinationally in the same cycle. The access commits at the next rising edge. Because only one access exists per cycle, event reads are serialized and two CPUs can never take the same source together. The address is `{view, offset}`. View 0 targets the CPU named on `bus_cpu`, and view v (1..N_CPU) targets CPU v-1. Only the event and IPI registers depend on the view.

Top module: `autoack_irq_ctrl`

## Requirements
- R1: After reset all source masks and IPI masks are set, software triggers, IPI pending bits and `irq_out` are zero, affinity is all ones, and an event read returns 0.
- R2: `irq_out[c]` is high in the same cycle whenever source s has (hw_irq[s] OR trigger[s]) AND NOT mask[s] AND affinity[s][c], or CPU c has an IPI that is pending and unmasked. It falls as soon as none does.
- R3: Offset 1 sets mask bits for each 1 written, and offset 2 clears them. A read of either offset returns the mask vector in bits [N_SRC-1:0].
- R4: Offset 3 sets software-trigger bits, and offset 4 clears them. A read of either returns the trigger vector. A trigger raises a request without any hardware line, and delivery does not clear it.
- R5: Offset 32+s holds the affinity of source s, where bit c enables delivery to CPU c. A source whose bit c is clear is never reported to CPU c.
- R6: The event register is at offset 0. It returns a kind in bits [17:16] (0 = none, 1 = hardware source, 2 = IPI) and a number in bits [15:0]. IPI 0 comes first, then IPI 1, then the lowest-numbered eligible source.
- R7: An event read that returns kind 1 sets that source's mask bit at the next edge.
- R8: An event read that returns kind 2 clears that IPI's pending bit and sets its IPI mask bit.
- R9: An event read that returns kind 0 changes no state.
- R10: View 0 addresses the CPU given on `bus_cpu`, and view v in 1..N_CPU addresses CPU v-1. Other views return 0 on per-CPU reads and ignore per-CPU writes.
- R11: The per-CPU IPI registers are at these offsets: 5 sets pending, 6 clears pending, 7 sets the IPI mask, 8 clears the IPI mask (bit k = IPI k in each). Offset 9 reads back {mask[1:0], pending[1:0]} in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | N_SRC | Level-sensitive hardware request lines |
| bus_valid | input | 1 | Register access present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_addr | input | VIEW_W+6 | {view, word offset} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | N_CPU | Per-CPU interrupt request |

## Verification
The hardest situation to reach is one CPU with a pending IPI, several hardware sources that are eligible at once, and affinity that excludes the other CPU. Here a single event read must pick the right winner and change exactly one bit of state. Directed steps build this by hand: they unmask a source, restrict its affinity, ring an IPI from the other CPU's view, and then drain events one by one. After that, seeded random traffic mixes line changes, set/clear writes, affinity writes, IPI operations and event reads through all views. It checks every read and `irq_out` against a bench model.

// File: rtl/aack_pkg.sv
package aack_pkg;
  localparam int OFF_W = 6;
  localparam int DW    = 32;

  localparam logic [OFF_W-1:0] OFF_EVENT = 6'd0;
  localparam logic [OFF_W-1:0] OFF_MSET  = 6'd1;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 6'd2;
  localparam logic [OFF_W-1:0] OFF_SSET  = 6'd3;
  localparam logic [OFF_W-1:0] OFF_SCLR  = 6'd4;
  localparam logic [OFF_W-1:0] OFF_ISET  = 6'd5;
  localparam logic [OFF_W-1:0] OFF_ICLR  = 6'd6;
  localparam logic [OFF_W-1:0] OFF_IMSET = 6'd7;
  localparam logic [OFF_W-1:0] OFF_IMCLR = 6'd8;
  localparam logic [OFF_W-1:0] OFF_ISTAT = 6'd9;
  localparam logic [OFF_W-1:0] OFF_AFF   = 6'd32;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HW   = 2'd1,
    EV_IPI  = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/aack_src_bank.sv
module aack_src_bank #(
  parameter int N_SRC = 16,
  parameter int N_CPU = 2,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              mask_set,
  input  logic [N_SRC-1:0]              mask_clr,
  input  logic [N_SRC-1:0]              auto_mask,
  input  logic [N_SRC-1:0]              swt_set,
  input  logic [N_SRC-1:0]              swt_clr,
  input  logic                          aff_we,
  input  logic [IDX_W-1:0]              aff_idx,
  input  logic [N_CPU-1:0]              aff_wdata,
  output logic [N_SRC-1:0]              mask_q,
  output logic [N_SRC-1:0]              swt_q,
  output logic [N_SRC-1:0][N_CPU-1:0]   aff_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swt_q  <= '0;
    end else begin
      mask_q <= (mask_q | mask_set | auto_mask) & ~mask_clr;
      swt_q  <= (swt_q | swt_set) & ~swt_clr;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_aff
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        aff_q[s] <= '1;
      else if (aff_we && aff_idx == IDX_W'(s))
        aff_q[s] <= aff_wdata;
    end
  end
endmodule

// File: rtl/aack_cpu_port.sv
module aack_cpu_port import aack_pkg::*; #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] elig_hw,
  input  logic [1:0]       ipi_set,
  input  logic [1:0]       ipi_clr,
  input  logic [1:0]       imask_set,
  input  logic [1:0]       imask_clr,
  input  logic             ack,
  output logic [DW-1:0]    event_o,
  output logic [3:0]       ipi_stat_o,
  output logic             irq_o,
  output logic [N_SRC-1:0] hw_ack_o
);
  logic [1:0]       pend_q, imask_q, ipi_elig, ipi_take;
  logic             hw_hit;
  logic [IDX_W-1:0] hw_num;
  ev_kind_e         kind;
  logic [15:0]      num;

  assign ipi_elig = pend_q & ~imask_q;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    hw_hit = 1'b0;
    hw_num = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_hw[i]) begin
        hw_hit = 1'b1;
        hw_num = IDX_W'(i);
      end
    end
  end

  always_comb begin
    kind = EV_NONE;
    num  = '0;
    if (ipi_elig[0]) begin
      kind = EV_IPI;
    end else if (ipi_elig[1]) begin
      kind = EV_IPI;
      num  = 16'd1;
    end else if (hw_hit) begin
      kind = EV_HW;
      num  = 16'(hw_num);
    end
  end

  assign event_o    = DW'({kind, num});
  assign ipi_stat_o = {imask_q, pend_q};
  assign irq_o      = (|ipi_elig) | hw_hit;
  assign hw_ack_o   = (ack && kind == EV_HW) ? (N_SRC'(1) << hw_num) : '0;
  assign ipi_take   = (ack && kind == EV_IPI) ? ((num == 16'd0) ? 2'b01 : 2'b10) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      imask_q <= '1;
    end else begin
      pend_q  <= (pend_q | ipi_set) & ~ipi_clr & ~ipi_take;
      imask_q <= (imask_q | imask_set | ipi_take) & ~imask_clr;
    end
  end
endmodule

// File: rtl/autoack_irq_ctrl.sv
module autoack_irq_ctrl import aack_pkg::*; #(
  parameter int N_SRC = 16,
  parameter int N_CPU = 2,
  localparam int CPU_W  = $clog2(N_CPU),
  localparam int VIEW_W = $clog2(N_CPU + 1),
  localparam int ADDR_W = VIEW_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  hw_irq,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_CPU-1:0]  irq_out
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [OFF_W-1:0]            off;
  logic [VIEW_W-1:0]           view;
  int                          tgt;
  logic                        tgt_ok, wr, rd, aff_hit;
  logic [IDX_W-1:0]            aff_idx;
  logic [N_SRC-1:0]            mask_q, swt_q, req, auto_mask;
  logic [N_SRC-1:0][N_CPU-1:0] aff_q;
  logic [DW-1:0]               ev   [N_CPU];
  logic [3:0]                  istat[N_CPU];
  logic [N_SRC-1:0]            hw_ack[N_CPU];

  assign off  = bus_addr[OFF_W-1:0];
  assign view = bus_addr[ADDR_W-1:OFF_W];
  assign wr   = bus_valid & bus_we;
  assign rd   = bus_valid & ~bus_we;
  assign req  = hw_irq | swt_q;

  always_comb begin
    if (view == '0) begin
      tgt    = int'(bus_cpu);
      tgt_ok = 1'b1;
    end else begin
      tgt    = int'(view) - 1;
      tgt_ok = int'(view) <= N_CPU;
    end
  end

  assign aff_hit = (off >= OFF_AFF) && (int'(off - OFF_AFF) < N_SRC);
  assign aff_idx = IDX_W'(off - OFF_AFF);

  function automatic logic [N_SRC-1:0] wbits(input logic hit);
    return hit ? bus_wdata[N_SRC-1:0] : '0;
  endfunction

  aack_src_bank #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_set  (wbits(wr && off == OFF_MSET)),
    .mask_clr  (wbits(wr && off == OFF_MCLR)),
    .auto_mask (auto_mask),
    .swt_set   (wbits(wr && off == OFF_SSET)),
    .swt_clr   (wbits(wr && off == OFF_SCLR)),
    .aff_we    (wr && aff_hit),
    .aff_idx   (aff_idx),
    .aff_wdata (bus_wdata[N_CPU-1:0]),
    .mask_q    (mask_q),
    .swt_q     (swt_q),
    .aff_q     (aff_q)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_SRC-1:0] col;
    logic             sel;
    for (genvar s = 0; s < N_SRC; s++) begin : g_col
      assign col[s] = aff_q[s][c];
    end
    assign sel = tgt_ok && (tgt == c);

    aack_cpu_port #(.N_SRC(N_SRC)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .elig_hw    (req & ~mask_q & col),
      .ipi_set    ((wr && sel && off == OFF_ISET)  ? bus_wdata[1:0] : 2'b00),
      .ipi_clr    ((wr && sel && off == OFF_ICLR)  ? bus_wdata[1:0] : 2'b00),
      .imask_set  ((wr && sel && off == OFF_IMSET) ? bus_wdata[1:0] : 2'b00),
      .imask_clr  ((wr && sel && off == OFF_IMCLR) ? bus_wdata[1:0] : 2'b00),
      .ack        (rd && sel && off == OFF_EVENT),
      .event_o    (ev[c]),
      .ipi_stat_o (istat[c]),
      .irq_o      (irq_out[c]),
      .hw_ack_o   (hw_ack[c])
    );
  end

  always_comb begin
    auto_mask = '0;
    for (int c = 0; c < N_CPU; c++) auto_mask |= hw_ack[c];
  end

  always_comb begin
    bus_rdata = '0;
    case (off)
      OFF_EVENT: for (int c = 0; c < N_CPU; c++) if (tgt_ok && tgt == c) bus_rdata = ev[c];
      OFF_ISTAT: for (int c = 0; c < N_CPU; c++) if (tgt_ok && tgt == c) bus_rdata[3:0] = istat[c];
      OFF_MSET, OFF_MCLR: bus_rdata[N_SRC-1:0] = mask_q;
      OFF_SSET, OFF_SCLR: bus_rdata[N_SRC-1:0] = swt_q;
      default: if (aff_hit) bus_rdata[N_CPU-1:0] = aff_q[aff_idx];
    endcase
  end
endmodule

module autoack_irq_ctrl_chk #(
  parameter int N_SRC  = 16,
  parameter int N_CPU  = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N_CPU-1:0]  irq_out,
  input logic [N_SRC-1:0]  mask
);
  localparam int SW = $clog2(N_SRC);
  logic ev_rd;
  assign ev_rd = bus_valid && !bus_we && bus_addr[5:0] == 6'd0;

  // R6
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |-> bus_rdata[17:16] != 2'd3);

  // R7
  auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && bus_rdata[17:16] == 2'd1) |=> mask[$past(bus_rdata[SW-1:0])]);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && bus_rdata[17:16] == 2'd0) |=> $stable(mask));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr[5:0] == 6'd1)
      |=> (mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]));

  for (genvar c = 0; c < N_CPU; c++) begin : g_quiet
    // R2
    quiet_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && int'(bus_addr[ADDR_W-1:6]) == c + 1 && !irq_out[c]) |-> bus_rdata[17:16] == 2'd0);
  end
endmodule

bind autoack_irq_ctrl autoack_irq_ctrl_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .mask      (mask_q)
);

// File: tb/autoack_irq_ctrl_bench.sv
module autoack_irq_ctrl_bench;
  localparam int NS = 16;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] hw_irq = '0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [0:0]  bus_cpu = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NC-1:0] irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [NS-1:0] m_mask, m_swt;
  logic [1:0]    m_aff [NS];
  logic [1:0]    m_pend [NC];
  logic [1:0]    m_imask[NC];

  always #5 clk = ~clk;

  autoack_irq_ctrl #(.N_SRC(NS), .N_CPU(NC)) u_autoack_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int resolve(input int cpu, input int view);
    if (view == 0) return cpu;
    if (view <= NC) return view - 1;
    return -1;
  endfunction

  function automatic logic [31:0] exp_event(input int c);
    logic [1:0] ie;
    logic [NS-1:0] el;
    if (c < 0) return 32'h0;
    ie = m_pend[c] & ~m_imask[c];
    if (ie[0]) return 32'h0002_0000;
    if (ie[1]) return 32'h0002_0001;
    for (int s = 0; s < NS; s++) el[s] = (hw_irq[s] | m_swt[s]) & ~m_mask[s] & m_aff[s][c];
    for (int s = 0; s < NS; s++) if (el[s]) return 32'h0001_0000 | s;
    return 32'h0;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = exp_event(c) != 32'h0;
    return r;
  endfunction

  task automatic acc(input bit we, input int cpu, input int view, input int off,
                     input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_cpu = 1'(cpu);
    bus_addr = {2'(view), 6'(off)}; bus_wdata = wd;
    #2 rd = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input int cpu, input int view, input int off, input logic [31:0] wd);
    logic [31:0] d;
    int t = resolve(cpu, view);
    acc(1'b1, cpu, view, off, wd, d);
    case (off)
      1: m_mask |= wd[NS-1:0];
      2: m_mask &= ~wd[NS-1:0];
      3: m_swt  |= wd[NS-1:0];
      4: m_swt  &= ~wd[NS-1:0];
      5: if (t >= 0) m_pend[t]  |= wd[1:0];
      6: if (t >= 0) m_pend[t]  &= ~wd[1:0];
      7: if (t >= 0) m_imask[t] |= wd[1:0];
      8: if (t >= 0) m_imask[t] &= ~wd[1:0];
      default: if (off >= 32 && off < 32 + NS) m_aff[off-32] = wd[1:0];
    endcase
  endtask

  task automatic rd(input string tag, input int cpu, input int view, input int off);
    logic [31:0] d, e;
    int t = resolve(cpu, view);
    e = 32'h0;
    case (off)
      0: e = exp_event(t);
      1, 2: e = 32'(m_mask);
      3, 4: e = 32'(m_swt);
      9: if (t >= 0) e = 32'({m_imask[t], m_pend[t]});
      default: if (off >= 32 && off < 32 + NS) e = 32'(m_aff[off-32]);
    endcase
    acc(1'b0, cpu, view, off, 32'h0, d);
    chk(tag, d, e);
    if (off == 0 && e[17:16] == 2'd1) m_mask[e[3:0]] = 1'b1;
    if (off == 0 && e[17:16] == 2'd2) begin
      m_pend[t][e[0]]  = 1'b0;
      m_imask[t][e[0]] = 1'b1;
    end
  endtask

  task automatic set_hw(input logic [NS-1:0] v);
    @(negedge clk); hw_irq = v; #1;
  endtask

  task automatic chk_irq(input string tag);
    #1 chk(tag, 32'(irq_out), 32'(exp_irq()));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    m_mask = '1; m_swt = '0;
    for (int s = 0; s < NS; s++) m_aff[s] = 2'b11;
    for (int c = 0; c < NC; c++) begin m_pend[c] = '0; m_imask[c] = 2'b11; end
    r = $urandom(32'h0005_eed1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_out), 32'h0);
    rd("R1 mask", 0, 0, 1);
    rd("R1 ipi stat", 0, 1, 9);
    rd("R1 event", 0, 0, 0);
    rd("R1 affinity", 1, 0, 37);

    // R3 set/clear mask
    wr(0, 0, 2, 32'h00F0);
    rd("R3 mask after clear", 0, 0, 2);
    wr(1, 0, 1, 32'h0030);
    rd("R3 mask after set", 1, 0, 1);

    // R2 level following
    set_hw(16'h0040);
    chk_irq("R2 line high");
    chk("R2 both cpus", 32'(irq_out), 32'h3);
    set_hw(16'h0000);
    chk("R2 line low", 32'(irq_out), 32'h0);

    // R5 affinity
    wr(0, 0, 38, 32'h2);
    set_hw(16'h00C0);
    wr(0, 0, 39, 32'h2);
    chk("R5 only cpu1", 32'(irq_out), 32'h2);
    rd("R5 cpu0 sees none", 0, 1, 0);

    // R6/R7 lowest first, auto-mask
    rd("R6 lowest wins", 0, 2, 0);
    rd("R7 mask set after ack", 0, 0, 1);
    rd("R6 next source", 1, 0, 0);
    chk_irq("R7 irq drops");

    // R9 empty read
    rd("R9 empty event", 1, 2, 0);
    rd("R9 mask unchanged", 0, 0, 1);

    // R4 software trigger
    set_hw(16'h0000);
    wr(0, 0, 2, 32'h0010);
    wr(0, 0, 3, 32'h0010);
    rd("R4 trigger readback", 0, 0, 4);
    chk_irq("R4 trigger raises irq");
    rd("R4 trigger delivered", 0, 1, 0);
    rd("R4 trigger kept", 0, 0, 3);
    wr(0, 0, 4, 32'h0010);

    // R8/R11 IPI over hardware, other-cpu doorbell
    wr(0, 0, 2, 32'h0100);
    set_hw(16'h0100);
    wr(0, 2, 5, 32'h2);
    wr(1, 0, 8, 32'h3);
    rd("R11 ipi stat", 0, 2, 9);
    rd("R8 ipi first", 1, 2, 0);
    rd("R8 ipi cleared and masked", 1, 2, 9);
    rd("R6 hw after ipi", 1, 0, 0);

    // R10 views
    wr(1, 0, 5, 32'h1);
    rd("R10 view0 reaches own cpu", 0, 2, 9);
    rd("R10 invalid view", 0, 3, 9);
    wr(0, 3, 8, 32'h3);
    rd("R10 invalid view write ignored", 1, 0, 9);
    chk_irq("R10 irq");

    // random phase
    for (int k = 0; k < 1500; k++) begin
      int op = $urandom % 10;
      case (op)
        0: set_hw(NS'($urandom & $urandom & $urandom));
        1: wr($urandom % 2, $urandom % 4, 2, $urandom & $urandom);
        2: wr($urandom % 2, $urandom % 4, 1, $urandom);
        3: wr($urandom % 2, $urandom % 4, 3, $urandom & $urandom & $urandom);
        4: wr($urandom % 2, $urandom % 4, 4, $urandom);
        5: wr($urandom % 2, 0, 32 + ($urandom % NS), $urandom);
        6: wr($urandom % 2, $urandom % 4, 5 + ($urandom % 4), $urandom);
        9: begin
          int o = $urandom % 4;
          int off = (o == 0) ? 1 : (o == 1) ? 3 : (o == 2) ? 9 : 32 + ($urandom % NS);
          rd("R3 R4 R5 R11 random readback", $urandom % 2, $urandom % 4, off);
        end
        default: rd("R6 R7 R8 random event", $urandom % 2, $urandom % 4, 0);
      endcase
      chk_irq("R2 random irq");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule